// File: doc/BRIEF.md
# Banked GPIO Interrupt Detector

This block watches a set of already-synchronized GPIO inputs and turns configured input conditions into sticky interrupt status bits. Each pin has two configuration bits, a level/edge select and an invert bit, that together choose one of four trigger modes. Each pin also has an input-sense enable that gates all detection for it. Status and enable bits are grouped into banks of `BANK_W` bits. A neighbouring register file decodes the bus and hands this block a write strobe for status, a write strobe for enables, a bank index and a data word.

Status bits are cleared by writing ones: each 1 in the data word clears the matching bit of the selected bank, and each 0 leaves its bit alone. A condition seen in the same cycle as a clear wins, so an edge that lands while software is acknowledging the previous one is not lost. Level modes keep re-asserting their bit for as long as the level holds. A single interrupt line is the OR over every pin of status AND enable. It is registered and lines up with the registered status and enable outputs.

Top module: `gpio_irq_detector`

## Requirements
- R1: With trig_level=0 and trig_inv=0 (rising mode), a pin whose sample is 1 while its sample one clock earlier was 0 sets its status bit at that clock edge.
- R2: With trig_level=0 and trig_inv=1 (falling mode), a pin whose sample is 0 while its sample one clock earlier was 1 sets its status bit at that clock edge. A rising transition does not set it.
- R3: With trig_level=1 and trig_inv=0 (low-level mode), the status bit is set at every clock edge where the pin is 0, so a clear has no lasting effect while the pin stays low.
- R4: With trig_level=1 and trig_inv=1 (high-level mode), the status bit is set at every clock edge where the pin is 1, so a clear has no lasting effect while the pin stays high.
- R5: While sense_en for a pin is 0, no mode sets its status bit. The pin's previous sample is still tracked, so turning sensing back on while the pin holds a steady level creates no edge.
- R6: A status write to bank b clears bit i of stat_o[b*BANK_W+i] for each 1 in wr_data[i]. Zero bits and other banks are unchanged. Without a status write no status bit ever goes from 1 to 0.
- R7: When a trigger condition and a clear of the same bit occur at the same clock edge, the bit is 1 afterwards.
- R8: An enable write to bank b replaces en_o[b*BANK_W +: pins in bank] with the low bits of wr_data. Status bits are set whatever their enable is.
- R9: irq_o equals the OR over all pins of stat_o AND en_o, in every cycle after reset.
- R10: Reset clears all status, all enables and irq_o. Writes with a wr_bank at or above the number of banks change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| sense_en | input | NUM_PINS | Per-pin input-sense enable (1 = detect) |
| trig_level | input | NUM_PINS | Per-pin mode select: 0 edge, 1 level |
| trig_inv | input | NUM_PINS | Per-pin invert: edge 0 rising / 1 falling; level 0 low / 1 high |
| stat_wr | input | 1 | Write-one-to-clear strobe for the status bank in wr_bank |
| en_wr | input | 1 | Write strobe for the enable bank in wr_bank |
| wr_bank | input | $clog2(NUM_BANKS)+1 | Bank index of the write |
| wr_data | input | BANK_W | Write data; bit i maps to pin wr_bank*BANK_W+i |
| stat_o | output | NUM_PINS | Registered status bits |
| en_o | output | NUM_PINS | Registered enable bits |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The properties assume pin_in, sense_en and the mode bits are already synchronous to clk and settle between edges. They also assume that at most one of the two write strobes is meaningful per bank per cycle. The edge properties also rely on pin_in being driven during reset, so that the two-cycle history behind an edge is defined at the first active cycle. The bench changes every input only on the falling clock edge. It holds pins at steady levels through reset and configuration, and its random phase draws bank indices past the last bank so that ignored writes get exercised.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Mode encoding is {trig_level, trig_inv}.
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_mode_e;

  // Number of pins that fall into bank b.
  function automatic int bank_pins(input int n_pins, input int bank_w, input int b);
    int left;
    left = n_pins - b * bank_w;
    return (left < bank_w) ? left : bank_w;
  endfunction

endpackage

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic cur,
  input  logic prv,
  input  logic sense,
  input  logic lvl,
  input  logic inv,
  output logic hit
);

  trig_mode_e mode;
  logic       raw;

  always_comb begin
    mode = trig_mode_e'({lvl, inv});
    unique case (mode)
      TRIG_RISE: raw = cur & ~prv;
      TRIG_FALL: raw = ~cur & prv;
      TRIG_LOW:  raw = ~cur;
      TRIG_HIGH: raw = cur;
      default:   raw = 1'b0;
    endcase
    hit = raw & sense;
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NP = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] cur,
  input  logic [NP-1:0] prv,
  input  logic [NP-1:0] sense,
  input  logic [NP-1:0] lvl,
  input  logic [NP-1:0] inv,
  input  logic          clr_we,
  input  logic          en_we,
  input  logic [NP-1:0] wdata,
  output logic [NP-1:0] stat_q,
  output logic [NP-1:0] en_q,
  output logic          hit_d
);

  logic [NP-1:0] ev;
  logic [NP-1:0] clr_mask;
  logic [NP-1:0] stat_d;
  logic [NP-1:0] en_d;

  for (genvar i = 0; i < NP; i++) begin : g_pin
    gpio_irq_trig u_trig (
      .cur   (cur[i]),
      .prv   (prv[i]),
      .sense (sense[i]),
      .lvl   (lvl[i]),
      .inv   (inv[i]),
      .hit   (ev[i])
    );
  end

  always_comb begin
    clr_mask = clr_we ? wdata : '0;
    // a fresh event outranks the clear of the same bit
    stat_d   = (stat_q & ~clr_mask) | ev;
    en_d     = en_we ? wdata : en_q;
    hit_d    = |(stat_d & en_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 72,
  parameter int BANK_W   = 32,
  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W,
  localparam int BSEL_W    = $clog2(NUM_BANKS) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] sense_en,
  input  logic [NUM_PINS-1:0] trig_level,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic                stat_wr,
  input  logic                en_wr,
  input  logic [BSEL_W-1:0]   wr_bank,
  input  logic [BANK_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] stat_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0]  prev_q;
  logic [NUM_BANKS-1:0] bank_hit;
  logic                 irq_q;

  // previous sample keeps tracking in reset and with sensing off
  always_ff @(posedge clk) begin
    prev_q <= pin_in;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    localparam int NP = bank_pins(NUM_PINS, BANK_W, b);

    logic sel;
    assign sel = (wr_bank == BSEL_W'(b));

    gpio_irq_bank #(.NP(NP)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .cur    (pin_in[LO +: NP]),
      .prv    (prev_q[LO +: NP]),
      .sense  (sense_en[LO +: NP]),
      .lvl    (trig_level[LO +: NP]),
      .inv    (trig_inv[LO +: NP]),
      .clr_we (stat_wr & sel),
      .en_we  (en_wr & sel),
      .wdata  (wr_data[NP-1:0]),
      .stat_q (stat_o[LO +: NP]),
      .en_q   (en_o[LO +: NP]),
      .hit_d  (bank_hit[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |bank_hit;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/gpio_irq_detector_chk.sv
module gpio_irq_detector_chk #(
  parameter int NUM_PINS = 72,
  parameter int BANK_W   = 32,
  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W,
  localparam int BSEL_W    = $clog2(NUM_BANKS) + 1,
  localparam int B0        = (NUM_PINS < BANK_W) ? NUM_PINS : BANK_W
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] sense_en,
  input logic [NUM_PINS-1:0] trig_level,
  input logic [NUM_PINS-1:0] trig_inv,
  input logic                stat_wr,
  input logic                en_wr,
  input logic [BSEL_W-1:0]   wr_bank,
  input logic [BANK_W-1:0]   wr_data,
  input logic [NUM_PINS-1:0] stat_o,
  input logic [NUM_PINS-1:0] en_o,
  input logic                irq_o
);

  p_rise_r1: assert property (@(posedge clk) disable iff (rst)
    (($past(sense_en & ~trig_level & ~trig_inv & pin_in) & ~$past(pin_in, 2)) & ~stat_o) == '0);

  p_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (($past(sense_en & ~trig_level & trig_inv & ~pin_in) & $past(pin_in, 2)) & ~stat_o) == '0);

  p_low_level_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(sense_en & trig_level & ~trig_inv & ~pin_in) & ~stat_o) == '0);

  p_high_level_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(sense_en & trig_level & trig_inv & pin_in) & ~stat_o) == '0);

  p_sense_off_r5: assert property (@(posedge clk) disable iff (rst)
    (~$past(sense_en) & ~$past(stat_o) & stat_o) == '0);

  p_no_clear_r6: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> (($past(stat_o) & ~stat_o) == '0));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !en_wr |=> $stable(en_o));

  p_en_load_r8: assert property (@(posedge clk) disable iff (rst)
    (en_wr && wr_bank == '0) |=> (en_o[B0-1:0] == $past(wr_data[B0-1:0])));

  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(stat_o & en_o));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (stat_o == '0 && en_o == '0 && !irq_o));

  p_bad_bank_r10: assert property (@(posedge clk) disable iff (rst)
    (en_wr && (int'(wr_bank) >= NUM_BANKS)) |=> $stable(en_o));

endmodule

bind gpio_irq_detector gpio_irq_detector_chk #(
  .NUM_PINS (NUM_PINS),
  .BANK_W   (BANK_W)
) u_chk (.*);

// File: tb/gpio_irq_detector_test.sv
module gpio_irq_detector_test;

  localparam int  NP  = 72;
  localparam int  BW  = 32;
  localparam int  NB  = 3;
  localparam int  BSW = 3;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pin_in, sense_en, trig_level, trig_inv;
  logic          stat_wr, en_wr;
  logic [BSW-1:0] wr_bank;
  logic [BW-1:0] wr_data;
  logic [NP-1:0] stat_o, en_o;
  logic          irq_o;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    cmp_on   = 0;
  string phase    = "R10";

  gpio_irq_detector #(.NUM_PINS(NP), .BANK_W(BW)) uut (
    .clk, .rst, .pin_in, .sense_en, .trig_level, .trig_inv,
    .stat_wr, .en_wr, .wr_bank, .wr_data, .stat_o, .en_o, .irq_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference: per-pin bit vectors updated at each rising edge
  logic [NP-1:0] m_stat, m_en, m_prev;
  logic          m_irq;

  always @(posedge clk) begin
    if (rst) begin
      m_stat = '0;
      m_en   = '0;
      m_irq  = 1'b0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        bit ev;
        bit here;
        here = (int'(wr_bank) == p / BW);
        if (stat_wr && here && wr_data[p % BW]) m_stat[p] = 1'b0;
        if (!trig_level[p]) ev = trig_inv[p] ? (!pin_in[p] && m_prev[p]) : (pin_in[p] && !m_prev[p]);
        else                ev = trig_inv[p] ? pin_in[p] : !pin_in[p];
        if (ev && sense_en[p]) m_stat[p] = 1'b1;
        if (en_wr && here) m_en[p] = wr_data[p % BW];
      end
      m_irq = |(m_stat & m_en);
    end
    m_prev = pin_in;
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(phase, "model stat_o", stat_o, m_stat);
      check(phase, "model en_o", en_o, m_en);
      check("R9", "model irq_o", NP'(irq_o), NP'(m_irq));
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wstat(input int b, input logic [BW-1:0] d);
    stat_wr = 1'b1; wr_bank = BSW'(b); wr_data = d;
    tick();
    stat_wr = 1'b0; wr_data = '0;
  endtask

  task automatic wen(input int b, input logic [BW-1:0] d);
    en_wr = 1'b1; wr_bank = BSW'(b); wr_data = d;
    tick();
    en_wr = 1'b0; wr_data = '0;
  endtask

  function automatic logic [NP-1:0] bitv(input int p);
    return NP'(1) << p;
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; stat_wr = 1'b0; en_wr = 1'b0; wr_bank = '0; wr_data = '0;
    sense_en = '1;
    pin_in = '0;
    pin_in[23:16] = '1;
    trig_level = '0; trig_inv = '0;
    trig_inv[15:8]   = '1;
    trig_level[23:16] = '1;
    trig_level[31:24] = '1; trig_inv[31:24] = '1;
    tick(3);
    rst = 1'b0;
    check("R10", "stat after reset", stat_o, '0);
    check("R10", "en after reset", en_o, '0);
    check("R10", "irq after reset", NP'(irq_o), '0);
    cmp_on = 1;
    tick(2);
    check("R10", "quiet pins", stat_o, '0);

    phase = "R1";
    pin_in[3] = 1'b1; tick();
    check("R1", "rising sets", stat_o, bitv(3));
    check("R8", "status set with enable off, irq", NP'(irq_o), '0);
    tick();
    wstat(0, 32'h8);
    check("R1", "held high no new edge", NP'(stat_o[3]), '0);
    pin_in[3] = 1'b0; tick();

    phase = "R2";
    pin_in[9] = 1'b1; tick();
    check("R2", "rise ignored in fall mode", NP'(stat_o[9]), '0);
    pin_in[9] = 1'b0; tick();
    check("R2", "falling sets", NP'(stat_o[9]), NP'(1));
    wstat(0, 32'h200);
    check("R2", "cleared", NP'(stat_o[9]), '0);

    phase = "R3";
    pin_in[17] = 1'b0; tick();
    check("R3", "low level sets", NP'(stat_o[17]), NP'(1));
    wstat(0, 32'h2_0000);
    check("R3", "clear while low no effect", NP'(stat_o[17]), NP'(1));
    pin_in[17] = 1'b1; tick();
    wstat(0, 32'h2_0000);
    check("R3", "clear after release", NP'(stat_o[17]), '0);

    phase = "R4";
    pin_in[26] = 1'b1; tick();
    check("R4", "high level sets", NP'(stat_o[26]), NP'(1));
    wstat(0, 32'h400_0000);
    check("R4", "clear while high no effect", NP'(stat_o[26]), NP'(1));
    pin_in[26] = 1'b0; tick();
    wstat(0, 32'h400_0000);
    check("R4", "clear after release", NP'(stat_o[26]), '0);

    phase = "R5";
    sense_en[5] = 1'b0; pin_in[5] = 1'b1; tick();
    check("R5", "edge with sense off", NP'(stat_o[5]), '0);
    sense_en[5] = 1'b1; tick(2);
    check("R5", "re-enable on steady level", NP'(stat_o[5]), '0);
    sense_en[25] = 1'b0; pin_in[25] = 1'b1; tick(2);
    check("R5", "level with sense off", NP'(stat_o[25]), '0);
    pin_in[25] = 1'b0; tick(); sense_en[25] = 1'b1; tick();

    phase = "R6";
    pin_in[40] = 1'b1; pin_in[0] = 1'b1; tick();
    check("R6", "two banks set", stat_o, bitv(0) | bitv(40));
    wstat(1, 32'h0);
    check("R6", "zero write no effect", stat_o, bitv(0) | bitv(40));
    wstat(0, 32'hFFFF_FFFE);
    check("R6", "bit0 kept", stat_o, bitv(0) | bitv(40));
    wstat(1, 32'hFFFF_FFFF);
    check("R6", "bank1 cleared only", stat_o, bitv(0));
    wstat(0, 32'hFFFF_FFFF);
    check("R6", "all clear", stat_o, '0);

    phase = "R7";
    pin_in[6] = 1'b1; tick();
    pin_in[6] = 1'b0; tick();
    check("R7", "bit set before race", NP'(stat_o[6]), NP'(1));
    pin_in[6] = 1'b1;
    wstat(0, 32'h40);
    check("R7", "set wins over clear", NP'(stat_o[6]), NP'(1));

    phase = "R8";
    check("R8", "irq with enables off", NP'(irq_o), '0);
    wen(0, 32'h40);
    check("R8", "enable bank0 load", en_o, bitv(6));
    check("R9", "irq with enabled status", NP'(irq_o), NP'(1));
    wen(3, 32'hFFFF_FFFF);
    check("R10", "enable to absent bank", en_o, bitv(6));
    wstat(5, 32'hFFFF_FFFF);
    check("R10", "clear to absent bank", NP'(stat_o[6]), NP'(1));
    phase = "R9";
    wen(0, 32'h0);
    check("R9", "irq off after disable", NP'(irq_o), '0);
    wen(0, 32'h40);
    wstat(0, 32'h40);
    check("R9", "irq off after clear", NP'(irq_o), '0);

    phase = "R8";
    pin_in[71] = 1'b1; tick();
    check("R1", "last pin rising", NP'(stat_o[71]), NP'(1));
    wen(2, 32'h80);
    check("R9", "irq from last bank", NP'(irq_o), NP'(1));
    wstat(2, 32'hFFFF_FFFF);
    check("R6", "last bank cleared", NP'(stat_o[71]), '0);
    wen(2, 32'hFFFF_FFFF);
    check("R8", "partial bank enable", NP'(en_o[71:64]), NP'(8'hFF));

    phase = "R6";
    for (int c = 0; c < 3000; c++) begin
      pin_in = pin_in ^ (NP'({$urandom(), $urandom(), $urandom()}) &
                         NP'({$urandom(), $urandom(), $urandom()}));
      if ($urandom_range(0, 15) == 0) begin
        trig_level = NP'({$urandom(), $urandom(), $urandom()});
        trig_inv   = NP'({$urandom(), $urandom(), $urandom()});
        sense_en   = NP'({$urandom(), $urandom(), $urandom()}) | NP'({$urandom(), $urandom(), $urandom()});
      end
      stat_wr = ($urandom_range(0, 3) == 0);
      en_wr   = ($urandom_range(0, 5) == 0);
      wr_bank = BSW'($urandom_range(0, 4));
      wr_data = ($urandom_range(0, 7) == 0) ? '1 : BW'($urandom());
      tick();
    end
    stat_wr = 1'b0; en_wr = 1'b0;
    tick(2);
    finish_run();
  end

endmodule